// File: doc/BRIEF.md
# Write-Combining Store Buffer

This block stands between a store source and a device-memory port on which every bus transfer is expensive. Word stores that land in the same aligned line are gathered in one open line register, and a per-word valid mask records which words already hold data. A store to a word that already holds data replaces that word. The line goes to the device as a single burst once its last missing word arrives. A run of stores to rising word addresses, such as neighbouring pixels, therefore costs exactly one transfer.

The open line is also sent out early in two cases. The first is a store that targets a different line: only the filled words go out, marked by the burst's word mask, and the new store opens the next line. The second is a flush request. The flush is acknowledged by a one-cycle `flush_done` once the device has taken the burst. If nothing was open, the acknowledgement comes right away instead. The store side stays ready while a line is open. It drops ready only while a burst is waiting for the device, or while a flush request is still waiting to be handled.

Top module: `wc_buffer`

## Requirements
- R1: After reset `bo_valid` and `flush_done` are 0, `st_ready` is 1 and no line is open.
- R2: A store accepted while the open line is not yet complete, and that targets the same line, produces no burst.
- R3: The burst for a completed line has `bo_mask` all ones. It appears on the clock edge that accepts the store filling the last word.
- R4: Stores to words 0 through WORDS-1 of one line, in rising order, produce exactly one burst.
- R5: A later store to a word that already holds data replaces that word's value in the eventual burst.
- R6: A store to a different line than the open one sends the open line out, with `bo_mask` bit i set exactly for the filled words. The store's word then becomes the only valid word of the new line.
- R7: A flush request while a line is open sends that partial line out. `flush_done` is high for the cycle after the device accepts that burst.
- R8: A flush request while no line is open produces no burst. `flush_done` goes high on the second clock edge after the request is sampled.
- R9: `st_ready` is low only while a burst is held with `bo_ready` low, or while a flush request is still pending.
- R10: While `bo_valid` is high and `bo_ready` is low, `bo_line`, `bo_mask` and `bo_data` hold their values.
- R11: A store address splits as follows. The low log2(WORDS) bits are the word index, and the remaining upper bits are the line number shown on `bo_line`. Word i occupies `bo_data` bits [i*DATA_W +: DATA_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted when high with st_valid |
| st_addr | input | ADDR_W | Word address of the store |
| st_data | input | DATA_W | Store data |
| flush_req | input | 1 | Request to send out the open line |
| flush_done | output | 1 | One-cycle flush acknowledgement |
| bo_valid | output | 1 | Burst available to the device |
| bo_ready | input | 1 | Device accepts the burst |
| bo_line | output | ADDR_W-log2(WORDS) | Line number of the burst |
| bo_mask | output | WORDS | Valid words in the burst |
| bo_data | output | WORDS*DATA_W | Burst data, word 0 in the low bits |

## Verification
The bench builds the block with WORDS=8, DATA_W=32 and ADDR_W=16, which gives 8-bit masks and 13-bit line numbers. With these values the bench can fill whole lines quickly, and it can reach the top line number 0x1FFF. A random phase spreads stores over three lines while `bo_ready` toggles. This makes a line change land while an earlier burst is still stalled, and makes flushes overlap held bursts, both against a behavioural queue-free model.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
   typedef enum logic [1:0] {
      DR_NONE  = 2'd0,
      DR_FULL  = 2'd1,
      DR_MISS  = 2'd2,
      DR_FLUSH = 2'd3
   } drain_e;
endpackage

// File: rtl/wcb_line_store.sv
module wcb_line_store #(
   parameter int WORDS  = 8,
   parameter int DATA_W = 32,
   parameter int LINE_W = 13,
   localparam int IDX_W = $clog2(WORDS),
   localparam int BUS_W = WORDS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              restart,
   input  logic              clr,
   input  logic [LINE_W-1:0] wr_line,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   output logic              open_q,
   output logic [LINE_W-1:0] line_q,
   output logic [WORDS-1:0]  mask_q,
   output logic [BUS_W-1:0]  data_q,
   output logic [WORDS-1:0]  merge_mask,
   output logic [BUS_W-1:0]  merge_data
);
   logic [WORDS-1:0] hot;

   assign hot        = {{(WORDS-1){1'b0}}, 1'b1} << wr_idx;
   assign merge_mask = mask_q | hot;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         mask_q <= '0;
         line_q <= '0;
      end else if (restart) begin
         open_q <= 1'b1;
         mask_q <= hot;
         line_q <= wr_line;
      end else if (clr) begin
         open_q <= 1'b0;
         mask_q <= '0;
      end else if (wr_en) begin
         open_q <= 1'b1;
         mask_q <= merge_mask;
         line_q <= wr_line;
      end
   end

   for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
      logic sel;
      assign sel = wr_idx == IDX_W'(gi);
      assign merge_data[gi*DATA_W +: DATA_W] = sel ? wr_data : data_q[gi*DATA_W +: DATA_W];
      always_ff @(posedge clk) begin
         if (!rst_n)
            data_q[gi*DATA_W +: DATA_W] <= '0;
         else if ((wr_en || restart) && sel)
            data_q[gi*DATA_W +: DATA_W] <= wr_data;
      end
   end
endmodule

// File: rtl/wcb_burst_reg.sv
module wcb_burst_reg #(
   parameter int WORDS  = 8,
   parameter int DATA_W = 32,
   parameter int LINE_W = 13,
   localparam int BUS_W = WORDS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [LINE_W-1:0] ld_line,
   input  logic [WORDS-1:0]  ld_mask,
   input  logic [BUS_W-1:0]  ld_data,
   input  logic              bo_ready,
   output logic              bo_valid,
   output logic [LINE_W-1:0] bo_line,
   output logic [WORDS-1:0]  bo_mask,
   output logic [BUS_W-1:0]  bo_data,
   output logic              free,
   output logic              fire
);
   assign free = !bo_valid || bo_ready;
   assign fire = bo_valid && bo_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bo_valid <= 1'b0;
         bo_line  <= '0;
         bo_mask  <= '0;
         bo_data  <= '0;
      end else if (load) begin
         bo_valid <= 1'b1;
         bo_line  <= ld_line;
         bo_mask  <= ld_mask;
         bo_data  <= ld_data;
      end else if (bo_ready) begin
         bo_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/wcb_drain_ctrl.sv
module wcb_drain_ctrl
   import wcb_pkg::*;
#(
   parameter int WORDS  = 8,
   parameter int LINE_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_valid,
   input  logic [LINE_W-1:0] st_line,
   input  logic              open_q,
   input  logic [LINE_W-1:0] line_q,
   input  logic [WORDS-1:0]  merge_mask,
   input  logic              out_free,
   input  logic              bo_fire,
   input  logic              flush_req,
   output logic              st_ready,
   output logic              wr_en,
   output logic              restart,
   output logic              clr,
   output drain_e            cause,
   output logic              flush_pend,
   output logic              flush_done
);
   logic acc, miss, full, flush_wait, flush_empty;

   assign st_ready    = out_free && !flush_pend;
   assign acc         = st_valid && st_ready;
   assign miss        = open_q && (st_line != line_q);
   assign full        = &merge_mask;
   assign flush_empty = flush_pend && out_free && !open_q;

   always_comb begin
      cause = DR_NONE;
      if (acc && miss)                        cause = DR_MISS;
      else if (acc && full)                   cause = DR_FULL;
      else if (flush_pend && out_free && open_q) cause = DR_FLUSH;
   end

   assign wr_en   = acc && !miss;
   assign restart = acc && miss;
   assign clr     = (cause == DR_FULL) || (cause == DR_FLUSH);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flush_pend <= 1'b0;
         flush_wait <= 1'b0;
         flush_done <= 1'b0;
      end else begin
         flush_pend <= (flush_pend && !out_free) || flush_req;
         flush_done <= flush_empty || (flush_wait && bo_fire);
         if (cause == DR_FLUSH)
            flush_wait <= 1'b1;
         else if (bo_fire)
            flush_wait <= 1'b0;
      end
   end
endmodule

// File: rtl/wc_buffer.sv
module wc_buffer
   import wcb_pkg::*;
#(
   parameter int WORDS  = 8,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 16,
   localparam int IDX_W  = $clog2(WORDS),
   localparam int LINE_W = ADDR_W - IDX_W,
   localparam int BUS_W  = WORDS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_valid,
   output logic              st_ready,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [DATA_W-1:0] st_data,
   input  logic              flush_req,
   output logic              flush_done,
   output logic              bo_valid,
   input  logic              bo_ready,
   output logic [LINE_W-1:0] bo_line,
   output logic [WORDS-1:0]  bo_mask,
   output logic [BUS_W-1:0]  bo_data
);
   if (WORDS < 2 || (1 << IDX_W) != WORDS) begin : g_bad_words
      $error("WORDS must be a power of two of at least 2");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("ADDR_W must exceed the word-index width");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic [LINE_W-1:0] st_line, line_q, ld_line;
   logic [IDX_W-1:0]  st_idx;
   logic              open_q, wr_en, restart, clr, out_free, bo_fire, flush_pend;
   logic [WORDS-1:0]  mask_q, merge_mask, ld_mask;
   logic [BUS_W-1:0]  data_q, merge_data, ld_data;
   drain_e            cause;

   assign st_idx  = st_addr[IDX_W-1:0];
   assign st_line = st_addr[ADDR_W-1:IDX_W];

   wcb_line_store #(.WORDS(WORDS), .DATA_W(DATA_W), .LINE_W(LINE_W)) u_line (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .restart(restart), .clr(clr),
      .wr_line(st_line), .wr_idx(st_idx), .wr_data(st_data),
      .open_q(open_q), .line_q(line_q), .mask_q(mask_q), .data_q(data_q),
      .merge_mask(merge_mask), .merge_data(merge_data)
   );

   wcb_drain_ctrl #(.WORDS(WORDS), .LINE_W(LINE_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_line(st_line),
      .open_q(open_q), .line_q(line_q), .merge_mask(merge_mask),
      .out_free(out_free), .bo_fire(bo_fire), .flush_req(flush_req),
      .st_ready(st_ready), .wr_en(wr_en), .restart(restart), .clr(clr),
      .cause(cause), .flush_pend(flush_pend), .flush_done(flush_done)
   );

   always_comb begin
      ld_line = line_q;
      ld_mask = mask_q;
      ld_data = data_q;
      if (cause == DR_FULL) begin
         ld_line = st_line;
         ld_mask = merge_mask;
         ld_data = merge_data;
      end
   end

   wcb_burst_reg #(.WORDS(WORDS), .DATA_W(DATA_W), .LINE_W(LINE_W)) u_out (
      .clk(clk), .rst_n(rst_n), .load(cause != DR_NONE),
      .ld_line(ld_line), .ld_mask(ld_mask), .ld_data(ld_data),
      .bo_ready(bo_ready), .bo_valid(bo_valid), .bo_line(bo_line),
      .bo_mask(bo_mask), .bo_data(bo_data), .free(out_free), .fire(bo_fire)
   );
endmodule

// File: rtl/wcb_checker.sv
module wcb_checker #(
   parameter int WORDS  = 8,
   parameter int DATA_W = 32,
   parameter int LINE_W = 13
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    st_valid,
   input logic                    st_ready,
   input logic                    flush_pend,
   input logic                    flush_done,
   input logic                    bo_valid,
   input logic                    bo_ready,
   input logic [LINE_W-1:0]       bo_line,
   input logic [WORDS-1:0]        bo_mask,
   input logic [WORDS*DATA_W-1:0] bo_data
);
   p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bo_valid && !bo_ready |=> bo_valid && $stable(bo_line) && $stable(bo_mask) && $stable(bo_data));

   p_ready_low_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !st_ready |-> flush_pend || (bo_valid && !bo_ready));

   p_mask_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bo_valid |-> bo_mask != '0);

   p_burst_has_trigger_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bo_valid) |-> $past(st_valid && st_ready) || $past(flush_pend));

   p_done_has_trigger_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flush_done) |-> $past(flush_pend) || $past(bo_valid && bo_ready));
endmodule

bind wc_buffer wcb_checker #(.WORDS(WORDS), .DATA_W(DATA_W), .LINE_W(LINE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
   .flush_pend(flush_pend), .flush_done(flush_done), .bo_valid(bo_valid),
   .bo_ready(bo_ready), .bo_line(bo_line), .bo_mask(bo_mask), .bo_data(bo_data)
);

// File: tb/sim_wc_buffer.sv
`timescale 1ns/1ps
module sim_wc_buffer;
   localparam int CLK_PERIOD = 10;
   localparam int WORDS = 8, DATA_W = 32, ADDR_W = 16;
   localparam int LINE_W = ADDR_W - 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic st_valid = 1'b0, st_ready, flush_req = 1'b0, flush_done;
   logic [ADDR_W-1:0] st_addr = '0;
   logic [DATA_W-1:0] st_data = '0;
   logic bo_valid, bo_ready = 1'b1;
   logic [LINE_W-1:0] bo_line;
   logic [WORDS-1:0] bo_mask;
   logic [WORDS*DATA_W-1:0] bo_data;

   wc_buffer #(.WORDS(WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u0 (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
      .st_addr(st_addr), .st_data(st_data), .flush_req(flush_req),
      .flush_done(flush_done), .bo_valid(bo_valid), .bo_ready(bo_ready),
      .bo_line(bo_line), .bo_mask(bo_mask), .bo_data(bo_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, errors = 0, bursts = 0, dones = 0;
   string cur_req = "R1";
   logic [LINE_W-1:0] cap_line;
   logic [WORDS-1:0] cap_mask;
   logic [WORDS*DATA_W-1:0] cap_data;

   // behavioural reference model
   logic m_open, m_ov, m_pend, m_wait, m_done;
   logic [LINE_W-1:0] m_line, m_oline;
   logic [WORDS-1:0] m_mask, m_omask;
   logic [DATA_W-1:0] m_data [WORDS];
   logic [DATA_W-1:0] m_odata [WORDS];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin : model
      logic fire, free, acc, ld, fl_ld, dn;
      logic [LINE_W-1:0] ln, nl;
      int idx;
      logic [WORDS-1:0] nm;
      logic [DATA_W-1:0] nd [WORDS];
      if (!rst_n) begin
         m_open = 0; m_ov = 0; m_pend = 0; m_wait = 0; m_done = 0;
         m_mask = '0; m_line = '0;
      end else begin
         fire = m_ov && bo_ready;
         free = !m_ov || bo_ready;
         acc  = st_valid && free && !m_pend;
         ln   = st_addr[ADDR_W-1:3];
         idx  = int'(st_addr[2:0]);
         ld = 0; fl_ld = 0; dn = 0;
         nl = '0; nm = '0;
         for (int i = 0; i < WORDS; i++) nd[i] = m_data[i];
         if (acc) begin
            if (m_open && ln != m_line) begin
               ld = 1; nl = m_line; nm = m_mask;
               m_mask = '0;
            end
            m_data[idx] = st_data;
            m_mask[idx] = 1'b1;
            m_line = ln;
            m_open = 1;
            if (m_mask == '1) begin
               ld = 1; nl = m_line; nm = m_mask;
               for (int i = 0; i < WORDS; i++) nd[i] = m_data[i];
               m_open = 0; m_mask = '0;
            end
         end else if (m_pend && free) begin
            if (m_open) begin
               ld = 1; fl_ld = 1; nl = m_line; nm = m_mask;
               m_open = 0; m_mask = '0;
            end else dn = 1;
         end
         if (m_wait && fire) dn = 1;
         if (fl_ld) m_wait = 1; else if (fire) m_wait = 0;
         m_pend = (m_pend && !free) || flush_req;
         m_done = dn;
         if (ld) begin
            m_ov = 1; m_oline = nl; m_omask = nm;
            for (int i = 0; i < WORDS; i++) m_odata[i] = nd[i];
         end else if (fire) m_ov = 0;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk(bo_valid === m_ov, cur_req, "bo_valid", 256'(bo_valid), 256'(m_ov));
         chk(flush_done === m_done, cur_req, "flush_done", 256'(flush_done), 256'(m_done));
         chk(st_ready === ((!m_ov || bo_ready) && !m_pend), "R9", "st_ready",
             256'(st_ready), 256'((!m_ov || bo_ready) && !m_pend));
         if (m_ov) begin
            chk(bo_line === m_oline, "R11", "bo_line", 256'(bo_line), 256'(m_oline));
            chk(bo_mask === m_omask, "R6", "bo_mask", 256'(bo_mask), 256'(m_omask));
            for (int i = 0; i < WORDS; i++)
               if (m_omask[i])
                  chk(bo_data[i*DATA_W +: DATA_W] === m_odata[i], "R5", "bo_data word",
                      256'(bo_data[i*DATA_W +: DATA_W]), 256'(m_odata[i]));
         end
         if (bo_valid && bo_ready) begin
            bursts++; cap_line = bo_line; cap_mask = bo_mask; cap_data = bo_data;
         end
         if (flush_done) dones++;
      end
   end

   task automatic store(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      logic r;
      st_valid = 1; st_addr = a; st_data = d;
      do begin
         @(negedge clk); r = st_ready;
         @(posedge clk); #1;
      end while (!r);
      st_valid = 0;
   endtask

   task automatic flush();
      flush_req = 1; @(posedge clk); #1; flush_req = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      int b0, d0;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk(bo_valid === 0 && flush_done === 0 && st_ready === 1, "R1", "reset outputs",
          256'({bo_valid, flush_done, st_ready}), 256'(3'b001));
      rst_n = 1; idle(1);

      // R4 / R3: rising fill of line 5
      cur_req = "R4"; b0 = bursts;
      for (int i = 0; i < WORDS; i++) store(ADDR_W'(5*8 + i), DATA_W'(32'h100 + i));
      chk(bo_valid === 1 && bo_mask === 8'hFF, "R3", "burst right after last word",
          256'({bo_valid, bo_mask}), 256'({1'b1, 8'hFF}));
      idle(3);
      chk(bursts - b0 == 1, "R4", "burst count", 256'(bursts - b0), 256'(1));
      chk(cap_line == 13'd5 && cap_data[3*32 +: 32] == 32'h103, "R11", "line and word 3",
          256'({cap_line, cap_data[3*32 +: 32]}), 256'({13'd5, 32'h103}));

      // R2: partial merge, no burst
      cur_req = "R2"; b0 = bursts;
      store(ADDR_W'(9*8 + 0), 32'hA0);
      store(ADDR_W'(9*8 + 2), 32'hA2);
      idle(3);
      chk(bursts == b0 && bo_valid === 0, "R2", "no burst for partial line",
          256'(bursts - b0), 256'(0));

      // R5 overwrite, then R6 line change
      cur_req = "R5";
      store(ADDR_W'(9*8 + 2), 32'hBB);
      cur_req = "R6";
      store(ADDR_W'(10*8 + 1), 32'hC1);
      idle(2);
      chk(cap_line == 13'd9 && cap_mask == 8'h05, "R6", "drained partial line",
          256'({cap_line, cap_mask}), 256'({13'd9, 8'h05}));
      chk(cap_data[2*32 +: 32] == 32'hBB, "R5", "overwritten word",
          256'(cap_data[2*32 +: 32]), 256'(32'hBB));

      // R7 flush of open line
      cur_req = "R7"; d0 = dones;
      flush(); idle(4);
      chk(cap_line == 13'd10 && cap_mask == 8'h02 && dones - d0 == 1, "R7", "flush drain",
          256'({cap_line, cap_mask, 8'(dones - d0)}), 256'({13'd10, 8'h02, 8'd1}));

      // R8 flush when empty
      cur_req = "R8"; b0 = bursts; d0 = dones;
      flush(); idle(3);
      chk(bursts == b0 && dones - d0 == 1, "R8", "empty flush",
          256'({8'(bursts - b0), 8'(dones - d0)}), 256'({8'd0, 8'd1}));

      // R9 / R10 stall
      cur_req = "R10"; bo_ready = 0;
      for (int i = 0; i < WORDS; i++) store(ADDR_W'(3*8 + i), DATA_W'(32'h300 + i));
      idle(4);
      chk(st_ready === 0 && bo_valid === 1, "R9", "ready low while burst stalled",
          256'({st_ready, bo_valid}), 256'(2'b01));
      bo_ready = 1; idle(2);
      chk(st_ready === 1, "R9", "ready back", 256'(st_ready), 256'(1));

      // R11 top line number
      cur_req = "R11";
      store(ADDR_W'(16'hFFFF), 32'hEE);
      flush(); idle(4);
      chk(cap_line == 13'h1FFF && cap_mask == 8'h80 && cap_data[7*32 +: 32] == 32'hEE,
          "R11", "address split", 256'({cap_line, cap_mask}), 256'({13'h1FFF, 8'h80}));

      // random traffic
      cur_req = "R6";
      for (int n = 0; n < 400; n++) begin
         bo_ready = ($urandom % 3) != 0;
         if (($urandom % 17) == 0) flush_req = 1;
         st_valid = ($urandom % 4) != 0;
         st_addr = ADDR_W'((20 + $urandom % 3) * 8 + $urandom % 8);
         st_data = $urandom;
         @(posedge clk); #1;
         flush_req = 0;
      end
      st_valid = 0; bo_ready = 1; flush(); idle(6);
      chk(bo_valid === 0 && st_ready === 1, "R7", "drained at end",
          256'({bo_valid, st_ready}), 256'(2'b01));

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule